// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block runs single bus cycles on a local bus whose lower address bits and data share one set of lines. An internal master places a request (cycle code, 20-bit address, write data, byte-high enable, CPU/DMA origin, lock). The controller walks the cycle through the address state T1, the data states T2 and T3, any number of wait states TW, and the closing state T4. Between cycles it idles in Ti. Along the way it drives the address latch strobe, the read and write strobes, the transceiver direction and enable, the byte-high enable, a three-bit cycle-type status and a CPU/DMA status bit on the upper address lines.

A ready input, already synchronized to the clock, stretches the cycle by one wait state for every clock on which it is sampled low. An external master can claim the bus through a hold request. The controller grants it only from idle or at the close of T4. While the grant is active, every shared bus and control line is released, and the address latch strobe stays driven low. Each pad group has an output enable, so that tri-state buffers can be built at the chip edge.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: A started cycle passes through T1, T2 and T3, then one TW for each clock on which `ready_i` is sampled low at the end of T3 or TW, then T4. `ack_o` is high during T4 only. On the edge that leaves the last T3/TW, `rdata_o` takes the value of `ad_i`.
- R2: `ale_o` rises on the falling clock edge just before T1 and falls on the falling edge inside T1. A request held high through T4 starts the next T1 directly, with `ale_o` rising in T4. `ale_o` is never released and is low while hold is granted.
- R3: In T1, `ad_o` carries the address bits 15..0 with `ad_oe_o` high, and `a_hi_o` carries address bits 19..16. From T2 through T4, `a_hi_o[3]` is 1 for a DMA cycle and 0 for a CPU cycle, and `a_hi_o[2:0]` are 0.
- R4: `sts_o` carries the cycle code in T1, T2, and T3/TW while `ready_i` is low. It returns to 111 in the clock where `ready_i` is high at the end of T3/TW, and it stays 111 in T4 and idle. The codes are: 101 memory read, 110 memory write, 001 I/O read, 010 I/O write, 100 instruction fetch, 000 interrupt acknowledge, 011 halt, 111 passive.
- R5: A write cycle (codes 010, 110) holds `wr_no` low in T2, T3 and TW. It drives the write data on `ad_o` with `ad_oe_o` high from T2 through T4, and holds `dtr_o` at 1.
- R6: A read cycle (codes 001, 100, 101) releases `ad_oe_o` from T2 through T4 and holds `dtr_o` at 0. `rd_no` falls on the falling edge inside T2, half a clock after the release, and rises on the falling edge inside T4. `rd_no` and `wr_no` are never low together.
- R7: `den_no` is low from T2 through T4 for every code except halt (011). It is high in T1, in idle, and in any clock where `dtr_o` changes. `dtr_o` changes only on entry to T1.
- R8: `bhe_no` carries the requested byte-high enable from T1 through T4 and is 1 in idle. Paired with address bit 0, the values are: 1/0 lower byte, 0/1 upper byte, 0/0 word.
- R9: `hold_i` is honoured only from idle or at the end of T4, and it takes priority over a pending request. `hlda_o` goes high in the clock after `hold_i` is seen, and a cycle already under way completes first.
- R10: While `hlda_o` is high, `ctl_oe_o`, `ad_oe_o` and `a_hi_oe_o` are all low. `hlda_o` falls in the clock after `hold_i` is sampled low.
- R11: While `rst_ni` is low, and until the first rising edge after its release, the control group is driven with `rd_no`, `wr_no`, `den_no` and `lock_no` high and `sts_o` = 111. In the same span `ad_oe_o` and `a_hi_oe_o` are low and `ale_o` and `hlda_o` are low. After that the control group is released until the first T1.
- R12: A locked request holds `lock_no` low from T1 through T4. An unlocked one leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request from the internal master |
| req_type_i | input | 3 | Cycle code of the request |
| req_addr_i | input | AW | Address of the request |
| req_wdata_i | input | DW | Write data of the request |
| req_bhe_ni | input | 1 | Byte-high enable of the request, active low |
| req_dma_i | input | 1 | Request comes from the DMA engine |
| req_lock_i | input | 1 | Request is locked |
| ready_i | input | 1 | Synchronized ready; low adds a wait state |
| hold_i | input | 1 | Bus request from an external master |
| ad_i | input | DW | Data read from the shared bus |
| ad_o | output | DW | Address/data driven onto the shared bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| a_hi_o | output | AW-DW | Upper address in T1, status afterwards |
| a_hi_oe_o | output | 1 | Output enable for a_hi_o |
| ale_o | output | 1 | Address latch strobe |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| den_no | output | 1 | Transceiver enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| bhe_no | output | 1 | Byte-high enable, active low |
| sts_o | output | 3 | Cycle-type status |
| lock_no | output | 1 | Bus lock, active low |
| ctl_oe_o | output | 1 | Output enable for strobes, status, lock, bhe, direction |
| hlda_o | output | 1 | Hold acknowledge |
| ack_o | output | 1 | High in T4 of each cycle |
| rdata_o | output | DW | Data captured at the end of the data phase |

## Verification
The contested moment is the end of T4, where a pending cycle request and an external hold request can both be live in the same clock. The bench raises `hold_i` during T1 of a read and keeps `req_i` high so that a second cycle is waiting. It then checks that the first cycle still finishes, that `hlda_o` rather than `ale_o` answers at the end of T4 with every bus group released, and that the waiting cycle starts only once `hold_i` has dropped and `hlda_o` has fallen.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  localparam int STS_W = 3;

  typedef enum logic [2:0] {
    ST_RST, ST_TI, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4, ST_TH
  } bus_st_e;

  localparam logic [STS_W-1:0] CY_INTA  = 3'b000;
  localparam logic [STS_W-1:0] CY_IORD  = 3'b001;
  localparam logic [STS_W-1:0] CY_IOWR  = 3'b010;
  localparam logic [STS_W-1:0] CY_HALT  = 3'b011;
  localparam logic [STS_W-1:0] CY_FETCH = 3'b100;
  localparam logic [STS_W-1:0] CY_MRD   = 3'b101;
  localparam logic [STS_W-1:0] CY_MWR   = 3'b110;
  localparam logic [STS_W-1:0] CY_PASS  = 3'b111;

  function automatic logic cyc_reads(logic [STS_W-1:0] t);
    return (t == CY_IORD) || (t == CY_FETCH) || (t == CY_MRD);
  endfunction

  function automatic logic cyc_writes(logic [STS_W-1:0] t);
    return (t == CY_IOWR) || (t == CY_MWR);
  endfunction

  function automatic logic cyc_moves_data(logic [STS_W-1:0] t);
    return (t != CY_HALT) && (t != CY_PASS);
  endfunction

  function automatic logic st_strobe(bus_st_e s);
    return (s == ST_T2) || (s == ST_T3) || (s == ST_TW);
  endfunction

  function automatic logic st_data(bus_st_e s);
    return st_strobe(s) || (s == ST_T4);
  endfunction
endpackage

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic    hold_i,
  input  logic    ready_i,
  output bus_st_e st_o,
  output logic    start_o,
  output logic    rfloat_o
);
  bus_st_e st_q, st_d;
  logic    rfloat_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RST:       st_d = ST_TI;
      ST_TI, ST_T4: st_d = hold_i ? ST_TH : (req_i ? ST_T1 : ST_TI);
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready_i ? ST_T4 : ST_TW;
      ST_TH:        st_d = hold_i ? ST_TH : ST_TI;
      default:      st_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_RST;
      rfloat_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (st_d == ST_T1) rfloat_q <= 1'b0;
    end
  end

  assign st_o     = st_q;
  assign start_o  = (st_d == ST_T1);
  assign rfloat_o = rfloat_q;
endmodule

// File: rtl/lbus_cap.sv
module lbus_cap
  import lbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  bus_st_e          st_i,
  input  logic             ready_i,
  input  logic [STS_W-1:0] req_type_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             req_bhe_ni,
  input  logic             req_dma_i,
  input  logic             req_lock_i,
  input  logic [DW-1:0]    ad_i,
  output logic [STS_W-1:0] cyc_type_o,
  output logic [AW-1:0]    cyc_addr_o,
  output logic [DW-1:0]    cyc_wdata_o,
  output logic             cyc_bhe_no,
  output logic             cyc_dma_o,
  output logic             cyc_lock_o,
  output logic             cyc_wr_o,
  output logic [DW-1:0]    rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_type_o  <= CY_PASS;
      cyc_addr_o  <= '0;
      cyc_wdata_o <= '0;
      cyc_bhe_no  <= 1'b1;
      cyc_dma_o   <= 1'b0;
      cyc_lock_o  <= 1'b0;
      cyc_wr_o    <= 1'b0;
    end else if (start_i) begin
      cyc_type_o  <= req_type_i;
      cyc_addr_o  <= req_addr_i;
      cyc_wdata_o <= req_wdata_i;
      cyc_bhe_no  <= req_bhe_ni;
      cyc_dma_o   <= req_dma_i;
      cyc_lock_o  <= req_lock_i;
      cyc_wr_o    <= cyc_writes(req_type_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        rdata_o <= '0;
    else if ((st_i == ST_T3 || st_i == ST_TW) && ready_i) rdata_o <= ad_i;
  end
endmodule

// File: rtl/lbus_half.sv
// Falling-edge strobes: ALE leads T1 by half a clock, RD trails the bus release.
module lbus_half
  import lbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  bus_st_e          st_i,
  input  logic [STS_W-1:0] cyc_type_i,
  output logic             ale_o,
  output logic             rd_no
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_o <= 1'b0;
      rd_no <= 1'b1;
    end else begin
      ale_o <= start_i;
      rd_no <= !(cyc_reads(cyc_type_i) && st_strobe(st_i));
    end
  end
endmodule

// File: rtl/lbus_drv.sv
module lbus_drv
  import lbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  bus_st_e          st_i,
  input  logic             rfloat_i,
  input  logic             ready_i,
  input  logic [STS_W-1:0] cyc_type_i,
  input  logic [AW-1:0]    cyc_addr_i,
  input  logic [DW-1:0]    cyc_wdata_i,
  input  logic             cyc_bhe_ni,
  input  logic             cyc_dma_i,
  input  logic             cyc_lock_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] a_hi_o,
  output logic             a_hi_oe_o,
  output logic             wr_no,
  output logic             den_no,
  output logic             bhe_no,
  output logic [STS_W-1:0] sts_o,
  output logic             lock_no,
  output logic             ctl_oe_o,
  output logic             hlda_o,
  output logic             ack_o
);
  localparam int HI_W = AW - DW;

  logic in_cyc, drive;

  assign in_cyc = (st_i == ST_T1) || st_data(st_i);
  assign drive  = (st_i == ST_RST) || ((st_i != ST_TH) && !rfloat_i);

  assign ctl_oe_o  = drive;
  assign a_hi_oe_o = drive && (st_i != ST_RST);
  assign ad_oe_o   = (st_i == ST_T1) || (st_data(st_i) && cyc_writes(cyc_type_i));
  assign ad_o      = (st_i == ST_T1) ? cyc_addr_i[DW-1:0] : cyc_wdata_i;
  assign a_hi_o    = (st_i == ST_T1) ? cyc_addr_i[AW-1:DW] : {cyc_dma_i, {(HI_W-1){1'b0}}};

  always_comb begin
    unique case (st_i)
      ST_T1, ST_T2: sts_o = cyc_type_i;
      ST_T3, ST_TW: sts_o = ready_i ? CY_PASS : cyc_type_i;
      default:      sts_o = CY_PASS;
    endcase
  end

  assign wr_no   = !(st_strobe(st_i) && cyc_writes(cyc_type_i));
  assign den_no  = !(st_data(st_i) && cyc_moves_data(cyc_type_i));
  assign bhe_no  = in_cyc ? cyc_bhe_ni : 1'b1;
  assign lock_no = !(in_cyc && cyc_lock_i);
  assign hlda_o  = (st_i == ST_TH);
  assign ack_o   = (st_i == ST_T4);
endmodule

// File: rtl/lbus_cycle_ctrl.sv
module lbus_cycle_ctrl
  import lbus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       req_type_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic             req_bhe_ni,
  input  logic             req_dma_i,
  input  logic             req_lock_i,
  input  logic             ready_i,
  input  logic             hold_i,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic [AW-DW-1:0] a_hi_o,
  output logic             a_hi_oe_o,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no,
  output logic             den_no,
  output logic             dtr_o,
  output logic             bhe_no,
  output logic [2:0]       sts_o,
  output logic             lock_no,
  output logic             ctl_oe_o,
  output logic             hlda_o,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o
);
  bus_st_e          st_q;
  logic             start, rfloat;
  logic [STS_W-1:0] cyc_type;
  logic [AW-1:0]    cyc_addr;
  logic [DW-1:0]    cyc_wdata;
  logic             cyc_bhe_n, cyc_dma, cyc_lock;

  lbus_seq u_seq (
    .clk_i, .rst_ni, .req_i, .hold_i, .ready_i,
    .st_o(st_q), .start_o(start), .rfloat_o(rfloat)
  );

  lbus_cap #(.AW(AW), .DW(DW)) u_cap (
    .clk_i, .rst_ni, .start_i(start), .st_i(st_q), .ready_i,
    .req_type_i, .req_addr_i, .req_wdata_i, .req_bhe_ni, .req_dma_i, .req_lock_i,
    .ad_i,
    .cyc_type_o(cyc_type), .cyc_addr_o(cyc_addr), .cyc_wdata_o(cyc_wdata),
    .cyc_bhe_no(cyc_bhe_n), .cyc_dma_o(cyc_dma), .cyc_lock_o(cyc_lock),
    .cyc_wr_o(dtr_o), .rdata_o
  );

  lbus_half u_half (
    .clk_i, .rst_ni, .start_i(start), .st_i(st_q), .cyc_type_i(cyc_type),
    .ale_o, .rd_no
  );

  lbus_drv #(.AW(AW), .DW(DW)) u_drv (
    .st_i(st_q), .rfloat_i(rfloat), .ready_i,
    .cyc_type_i(cyc_type), .cyc_addr_i(cyc_addr), .cyc_wdata_i(cyc_wdata),
    .cyc_bhe_ni(cyc_bhe_n), .cyc_dma_i(cyc_dma), .cyc_lock_i(cyc_lock),
    .ad_o, .ad_oe_o, .a_hi_o, .a_hi_oe_o, .wr_no, .den_no, .bhe_no,
    .sts_o, .lock_no, .ctl_oe_o, .hlda_o, .ack_o
  );
endmodule

// File: rtl/lbus_cycle_ctrl_chk.sv
module lbus_cycle_ctrl_chk
  import lbus_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_i,
  input logic       ready_i,
  input bus_st_e    st,
  input logic       ad_oe_o,
  input logic       a_hi_oe_o,
  input logic       ctl_oe_o,
  input logic       ale_o,
  input logic       rd_no,
  input logic       wr_no,
  input logic       den_no,
  input logic       dtr_o,
  input logic [2:0] sts_o,
  input logic       hlda_o,
  input logic       ack_o
);
  p_tw_insert_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_T3 || st == ST_TW) && !ready_i) |=> (st == ST_TW));
  p_t4_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_T3 || st == ST_TW) && ready_i) |=> (st == ST_T4));
  p_ale_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> !ale_o);
  p_sts_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (sts_o == 3'b111));
  p_wr_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (ad_oe_o && dtr_o));
  p_rd_float_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);
  p_rd_float_neg_r6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);
  p_strobe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));
  p_den_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dtr_o) |-> den_no);
  p_grant_point_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hlda_o) |-> ($past(st == ST_T4) || $past(st == ST_TI)));
  p_hold_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ctl_oe_o && !ad_oe_o && !a_hi_oe_o));
  p_hlda_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> !hlda_o);
endmodule

bind lbus_cycle_ctrl lbus_cycle_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .ready_i(ready_i), .st(st_q),
  .ad_oe_o(ad_oe_o), .a_hi_oe_o(a_hi_oe_o), .ctl_oe_o(ctl_oe_o), .ale_o(ale_o),
  .rd_no(rd_no), .wr_no(wr_no), .den_no(den_no), .dtr_o(dtr_o), .sts_o(sts_o),
  .hlda_o(hlda_o), .ack_o(ack_o)
);

// File: tb/lbus_cycle_ctrl_test.sv
module lbus_cycle_ctrl_test;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, req_bhe_ni = 1'b1, req_dma_i = 1'b0, req_lock_i = 1'b0;
  logic [2:0] req_type_i = 3'b111;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0, ad_i = '0;
  logic ready_i = 1'b1, hold_i = 1'b0;
  logic [DW-1:0] ad_o, rdata_o;
  logic [AW-DW-1:0] a_hi_o;
  logic [2:0] sts_o;
  logic ad_oe_o, a_hi_oe_o, ale_o, rd_no, wr_no, den_no, dtr_o, bhe_no;
  logic lock_no, ctl_oe_o, hlda_o, ack_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  lbus_cycle_ctrl #(.AW(AW), .DW(DW)) uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();    @(posedge clk_i); #2; endtask
  task automatic half();    @(negedge clk_i); #1; endtask

  function automatic logic rd_t(logic [2:0] t); return t == 3'b001 || t == 3'b100 || t == 3'b101; endfunction
  function automatic logic wr_t(logic [2:0] t); return t == 3'b010 || t == 3'b110; endfunction
  function automatic logic dat_t(logic [2:0] t); return t != 3'b011 && t != 3'b111; endfunction

  task automatic set_req(input logic [2:0] t, input logic [19:0] a, input logic [15:0] wd,
                         input logic bhe, input logic dma, input logic lk);
    req_i = 1'b1; req_type_i = t; req_addr_i = a; req_wdata_i = wd;
    req_bhe_ni = bhe; req_dma_i = dma; req_lock_i = lk;
  endtask

  // One full cycle from idle back to idle.
  task automatic run_cycle(input logic [2:0] t, input logic [19:0] a, input logic [15:0] wd,
                           input logic bhe, input logic dma, input logic lk,
                           input int waits, input logic [15:0] rd_val);
    set_req(t, a, wd, bhe, dma, lk);
    ready_i = 1'b1; ad_i = rd_val;
    half();
    check("R2 ale high before T1", ale_o, 1'b1);
    step(); req_i = 1'b0;                                   // T1
    check("R2 ale in T1", ale_o, 1'b1);
    check("R3 ad oe in T1", ad_oe_o, 1'b1);
    check("R3 addr low in T1", ad_o, a[15:0]);
    check("R3 addr high in T1", a_hi_o, a[19:16]);
    check("R4 status in T1", sts_o, t);
    check("R8 bhe in T1", bhe_no, bhe);
    check("R7 den high in T1", den_no, 1'b1);
    check("R12 lock in T1", lock_no, !lk);
    check("R5 R6 direction", dtr_o, wr_t(t));
    half();
    check("R2 ale low mid T1", ale_o, 1'b0);
    step();                                                 // T2
    check("R3 cpu/dma status", a_hi_o, dma ? 4'h8 : 4'h0);
    check("R5 wr strobe T2", wr_no, !wr_t(t));
    check("R5 R6 ad oe T2", ad_oe_o, wr_t(t));
    check("R6 rd high at T2 start", rd_no, 1'b1);
    check("R7 den T2", den_no, !dat_t(t));
    check("R4 status T2", sts_o, t);
    if (wr_t(t)) check("R5 write data", ad_o, wd);
    ready_i = (waits == 0);
    half();
    check("R6 rd mid T2", rd_no, !rd_t(t));
    step();                                                 // T3
    check("R4 status T3", sts_o, (waits == 0) ? 3'b111 : t);
    check("R1 no ack T3", ack_o, 1'b0);
    check("R5 wr strobe T3", wr_no, !wr_t(t));
    for (int i = 1; i <= waits; i++) begin
      step(); ready_i = (i == waits); #1;                   // TW
      check("R1 no ack TW", ack_o, 1'b0);
      check("R5 wr strobe TW", wr_no, !wr_t(t));
      check("R4 status TW", sts_o, (i == waits) ? 3'b111 : t);
    end
    step();                                                 // T4
    check("R1 ack T4", ack_o, 1'b1);
    check("R4 passive T4", sts_o, 3'b111);
    check("R5 wr released T4", wr_no, 1'b1);
    check("R7 den T4", den_no, !dat_t(t));
    check("R12 lock T4", lock_no, !lk);
    if (rd_t(t)) check("R1 read data", rdata_o, rd_val);
    half();
    check("R6 rd released mid T4", rd_no, 1'b1);
    step();                                                 // Ti
    check("R1 ack gone", ack_o, 1'b0);
    check("R8 bhe idle", bhe_no, 1'b1);
    check("R12 lock idle", lock_no, 1'b1);
    check("R2 no ale idle", ale_o, 1'b0);
  endtask

  task automatic t_reset();
    step(); step();
    check("R11 ctl driven in reset", ctl_oe_o, 1'b1);
    check("R11 rd high", rd_no, 1'b1);
    check("R11 wr high", wr_no, 1'b1);
    check("R11 den high", den_no, 1'b1);
    check("R11 lock high", lock_no, 1'b1);
    check("R11 status passive", sts_o, 3'b111);
    check("R11 ad floated", ad_oe_o, 1'b0);
    check("R11 upper floated", a_hi_oe_o, 1'b0);
    check("R11 ale low", ale_o, 1'b0);
    check("R11 hlda low", hlda_o, 1'b0);
    @(posedge clk_i); #1 rst_ni = 1'b1; #1;
    check("R11 driven after release", ctl_oe_o, 1'b1);
    step();
    check("R11 ctl floated", ctl_oe_o, 1'b0);
    check("R11 ad still floated", ad_oe_o, 1'b0);
  endtask

  task automatic t_hold_idle();
    hold_i = 1'b1;
    step();
    check("R9 hlda from idle", hlda_o, 1'b1);
    check("R10 ctl floated", ctl_oe_o, 1'b0);
    check("R10 ad floated", ad_oe_o, 1'b0);
    check("R10 upper floated", a_hi_oe_o, 1'b0);
    check("R2 ale low in hold", ale_o, 1'b0);
    step();
    check("R10 hlda held", hlda_o, 1'b1);
    hold_i = 1'b0;
    step();
    check("R10 hlda drops", hlda_o, 1'b0);
    check("R10 ctl back", ctl_oe_o, 1'b1);
  endtask

  task automatic t_hold_mid();
    set_req(3'b101, 20'h4_2460, 16'h0, 1'b0, 1'b0, 1'b0);
    ad_i = 16'h5A5A; ready_i = 1'b1;
    half();
    step(); hold_i = 1'b1;                                  // T1; req stays high
    step();
    check("R9 no grant in T2", hlda_o, 1'b0);
    step();
    check("R9 no grant in T3", hlda_o, 1'b0);
    step();
    check("R9 cycle finishes", ack_o, 1'b1);
    check("R9 no grant in T4", hlda_o, 1'b0);
    half();
    check("R9 hold beats request", ale_o, 1'b0);
    step();
    check("R9 grant after T4", hlda_o, 1'b1);
    check("R10 floated in grant", {ctl_oe_o, ad_oe_o, a_hi_oe_o}, 3'b000);
    hold_i = 1'b0;
    step();
    check("R10 hlda falls", hlda_o, 1'b0);
    half();
    check("R9 pending cycle resumes", ale_o, 1'b1);
    step(); req_i = 1'b0;
    check("R3 deferred address", ad_o, 16'h2460);
    step(); step(); step();
    check("R1 deferred ack", ack_o, 1'b1);
    check("R1 deferred data", rdata_o, 16'h5A5A);
    step();
  endtask

  task automatic t_back_to_back();
    set_req(3'b110, 20'h0_1234, 16'hBEEF, 1'b0, 1'b0, 1'b0);
    ready_i = 1'b1;
    half();
    step();                                                 // T1 of write
    set_req(3'b001, 20'h0_0301, 16'h0, 1'b0, 1'b0, 1'b0);
    step(); step(); step();                                 // T4
    check("R1 write ack", ack_o, 1'b1);
    half();
    check("R2 ale rises in T4", ale_o, 1'b1);
    step(); req_i = 1'b0;                                   // T1 of read
    check("R2 no idle between", ad_o, 16'h0301);
    check("R7 direction flips", dtr_o, 1'b0);
    check("R7 den high on flip", den_no, 1'b1);
    check("R8 upper byte pairing", {bhe_no, ad_o[0]}, 2'b01);
    step(); step(); step();
    check("R1 read ack", ack_o, 1'b1);
    step();
  endtask

  initial begin
    t_reset();
    run_cycle(3'b101, 20'hF_1000, 16'h0, 1'b0, 1'b0, 1'b0, 0, 16'hC0DE);
    check("R11 ctl driven after first cycle", ctl_oe_o, 1'b1);
    run_cycle(3'b010, 20'h0_0080, 16'h1357, 1'b0, 1'b0, 1'b0, 2, 16'h0);
    run_cycle(3'b100, 20'hA_BCD1, 16'h0, 1'b0, 1'b1, 1'b1, 1, 16'h9876);
    run_cycle(3'b110, 20'h3_0002, 16'h00AA, 1'b1, 1'b1, 1'b0, 3, 16'h0);
    run_cycle(3'b011, 20'h0_0000, 16'h0, 1'b1, 1'b0, 1'b0, 0, 16'h0);
    run_cycle(3'b000, 20'h0_0000, 16'h0, 1'b0, 1'b0, 1'b1, 0, 16'h0042);
    run_cycle(3'b001, 20'h0_0FF0, 16'h0, 1'b0, 1'b0, 1'b0, 4, 16'h7E7E);
    t_hold_idle();
    t_hold_mid();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule